// File: doc/BRIEF.md
# SPI Streaming Buffer Write Port

This block is a serial-peripheral slave that lets a host stream bytes into an 8-Kbyte packet buffer. The SPI link runs in mode 0 with the most significant bit first. The host lowers chip select and sends one command byte. If that byte is the buffer-write command, every later group of eight serial clocks forms a data byte. Each data byte goes out on a RAM write port, at the address held in a 13-bit write pointer.

When auto-increment is enabled, the pointer advances by one after each stored byte and wraps from the top of memory to zero. A host can therefore write a long run of sequential bytes inside a single chip-select frame with no further command overhead. A control register loads the pointer directly and supplies the auto-increment enable.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronisers, and SCK rising edges are detected in the system clock domain. The serial clock must therefore be several times slower than the system clock. The serial output is never driven.

Top module: `spi_bufwr_port`

## Requirements
- R1: After reset, `wr_ptr` is 0000h and `ram_we` is low.
- R2: A frame whose first byte is 7Ah writes each later complete byte to the RAM. That byte carries opcode 011 in bits 7:5 and argument 11010 in bits 4:0. SI is sampled on SCK rising edges, MSb first. `ram_wdata` carries the byte and `ram_addr` carries the current `wr_ptr`.
- R3: A frame whose first byte differs from 7Ah, in either the opcode or the argument, produces no RAM write and leaves the pointer unchanged until CS_n rises.
- R4: With `auto_inc_en` high, the pointer advances by one after each written byte, so successive bytes of a frame land at successive addresses.
- R5: With `auto_inc_en` high, a write to 1FFFh leaves the pointer at 0000h.
- R6: With `auto_inc_en` low, every byte of a frame is written to the same address and the pointer does not move.
- R7: If CS_n rises while a byte is only partly received, that byte is discarded. No write occurs, the pointer keeps its value, and the next frame starts from a fresh command byte.
- R8: A one-cycle `ptr_load` pulse sets the pointer to `ptr_load_val` on the next clock. A load takes priority over an increment in the same cycle.
- R9: `so_oe` stays low at all times, so the serial output remains high-impedance.
- R10: `ram_we` is a single-cycle pulse per completed data byte and never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| si | input | 1 | Serial data in, asynchronous |
| so_oe | output | 1 | Serial output enable, held low |
| auto_inc_en | input | 1 | Advance the pointer after each written byte |
| ptr_load | input | 1 | Load the write pointer |
| ptr_load_val | input | 13 | Value loaded into the pointer |
| wr_ptr | output | 13 | Current write pointer |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 13 | RAM write address |
| ram_wdata | output | 8 | RAM write data |

## Verification
A wrong bit count or a stale shift register shows up at the RAM port as corrupted `ram_wdata` on the very next write of the frame, and every following byte in the frame is misaligned as well. A pointer that steps wrongly or fails to wrap shows up as a wrong `ram_addr` on the next write. The pointer is also visible directly on `wr_ptr` after the frame ends. A command decoder left in the wrong state shows up either as writes in a rejected frame or as missing writes in an accepted one. Both are counted against the expected write log at the end of each frame.

// File: rtl/spi_bufwr_pkg.sv
// Shared constants and types for the SPI streaming buffer write port.
// Assumes an 8-Kbyte byte-wide buffer.
package spi_bufwr_pkg;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam logic [2:0] CMD_OPCODE = 3'b011;
    localparam logic [4:0] CMD_ARG    = 5'h1A;
    localparam logic [7:0] CMD_BYTE   = {CMD_OPCODE, CMD_ARG};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } frame_state_t;
endpackage

// File: rtl/spi_bufwr_sync.sv
// Brings SCK, CS_n and SI into the system clock domain through STAGES-deep
// flop chains and flags SCK rising edges. Assumes STAGES >= 2 and an SCK
// phase of at least two system clocks.
module spi_bufwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic si_in,
    output logic sck_rise,
    output logic frame_on,
    output logic si_bit
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] si_pipe;
    logic              sck_prev;

    // Synchroniser chains plus one history flop for SCK edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            cs_pipe  <= '1;
            si_pipe  <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_in};
            si_pipe  <= {si_pipe[STAGES-2:0], si_in};
            sck_prev <= sck_pipe[STAGES-1];
        end
    end

    assign sck_rise = sck_pipe[STAGES-1] & ~sck_prev;
    assign frame_on = ~cs_pipe[STAGES-1];
    assign si_bit   = si_pipe[STAGES-1];

    // Rising-edge flags never come back to back.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise);
endmodule

// File: rtl/spi_bufwr_shifter.sv
// Assembles serial bits into bytes, MSb first, on each synchronised SCK
// rise. It raises byte_vld for one clock per complete byte. Leaving the
// frame clears the bit count, so a partial byte is lost.
module spi_bufwr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              sck_rise,
    input  logic              si_bit,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] next_shreg;

    assign next_shreg = {shreg[DATA_W-2:0], si_bit};

    // Shift in one bit per SCK rise and publish the byte on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (sck_rise) begin
                shreg <= next_shreg;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Output byte register, updated only when a byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (frame_on && sck_rise && bit_cnt == LAST_BIT) begin
            byte_q <= next_shreg;
        end
    end

    assert_partial_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |=> (bit_cnt == '0) && !byte_vld);
    assert_byte_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_bufwr_ctrl.sv
// Per-frame command decoder. The first byte after CS_n falls must equal
// the buffer-write command. If it does, every later byte is a write;
// otherwise the frame is skipped until CS_n rises.
module spi_bufwr_ctrl
    import spi_bufwr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_q,
    output logic              wr_strobe
);
    frame_state_t state;

    // Frame state: idle, waiting for the command byte, writing, or skipping.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state <= ST_CMD;
                ST_CMD: begin
                    if (byte_vld) begin
                        state <= (byte_q == DATA_W'(CMD_BYTE)) ? ST_DATA : ST_SKIP;
                    end
                end
                ST_DATA: state <= ST_DATA;
                ST_SKIP: state <= ST_SKIP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_strobe = (state == ST_DATA) && byte_vld && frame_on;

    assert_skip_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> (state != ST_DATA));
    assert_write_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(frame_on));
endmodule

// File: rtl/spi_bufwr_ptr.sv
// 13-bit (ADDR_W) write pointer. A load takes priority over an increment.
// Increments wrap modulo the buffer size.
module spi_bufwr_ptr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    // Pointer register: load, then step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(load_val));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && ptr == TOP) |=> ptr == '0);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(ptr));
endmodule

// File: rtl/spi_bufwr_port.sv
// Top level: SPI slave that streams bytes into a packet buffer RAM at an
// auto-advancing write pointer. Assumes SCK is several times slower than clk.
module spi_bufwr_port
    import spi_bufwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so_oe,
    input  logic              auto_inc_en,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_load_val,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    logic              sck_rise;
    logic              frame_on;
    logic              si_bit;
    logic              byte_vld;
    logic [DATA_W-1:0] byte_q;
    logic              wr_strobe;

    spi_bufwr_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_in(sck), .cs_n_in(cs_n), .si_in(si),
        .sck_rise(sck_rise), .frame_on(frame_on), .si_bit(si_bit)
    );

    spi_bufwr_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .sck_rise(sck_rise),
        .si_bit(si_bit), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    spi_bufwr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .byte_vld(byte_vld),
        .byte_q(byte_q), .wr_strobe(wr_strobe)
    );

    spi_bufwr_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
        .step(wr_strobe && auto_inc_en), .ptr(wr_ptr)
    );

    assign so_oe     = 1'b0;
    assign ram_we    = wr_strobe;
    assign ram_addr  = wr_ptr;
    assign ram_wdata = byte_q;

    assert_step_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && auto_inc_en && !ptr_load) |=> wr_ptr == $past(ram_addr) + 1'b1);
endmodule

// File: tb/spi_bufwr_port_tb.sv
module spi_bufwr_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic        so_oe;
    logic        auto_inc_en = 1'b1;
    logic        ptr_load = 1'b0;
    logic [12:0] ptr_load_val = '0;
    logic [12:0] wr_ptr, ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;

    int n_checks = 0, n_err = 0;
    int wr_total = 0, so_bad = 0, we_bad = 0;
    logic        prev_we = 1'b0;
    logic [12:0] log_addr [256];
    logic [7:0]  log_data [256];
    logic [12:0] exp_ptr = '0;

    always #4 clk = ~clk;

    spi_bufwr_port dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so_oe(so_oe),
        .auto_inc_en(auto_inc_en), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .wr_ptr(wr_ptr), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // Write log and port monitors, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (so_oe !== 1'b0) so_bad++;
            if (ram_we && prev_we) we_bad++;
            if (ram_we) begin
                log_addr[wr_total % 256] = ram_addr;
                log_data[wr_total % 256] = ram_wdata;
                wr_total++;
            end
            prev_we = ram_we;
        end
    end

    function automatic logic [12:0] next_ptr(input logic [12:0] p, input bit inc);
        return inc ? p + 13'd1 : p;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        si = b;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic load_ptr(input logic [12:0] v);
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_load_val = v;
        @(negedge clk);
        ptr_load = 1'b0;
        check(wr_ptr == v, "R8", "loaded pointer", wr_ptr, v);
        exp_ptr = v;
    endtask

    task automatic run_frame(input logic [7:0] cmd, input int nbytes,
                             input int extra_bits, input bit inc);
        int start;
        int exp_n;
        logic [12:0] p;
        logic [7:0] d [16];
        bit good;
        start = wr_total;
        p = exp_ptr;
        good = (cmd == 8'h7A);
        auto_inc_en = inc;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(6);
        send_byte(cmd);
        for (int i = 0; i < nbytes; i++) begin
            d[i] = 8'($urandom);
            send_byte(d[i]);
        end
        for (int i = 0; i < extra_bits; i++) send_bit(1'($urandom));
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(8);
        exp_n = good ? nbytes : 0;
        check(wr_total - start == exp_n, good ? "R2" : "R3", "write count",
              wr_total - start, exp_n);
        if (wr_total - start == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                check(log_addr[(start + i) % 256] == p,
                      (p == 13'h0 && i > 0 && inc) ? "R5" : (inc ? "R4" : "R6"),
                      "write address", log_addr[(start + i) % 256], p);
                check(log_data[(start + i) % 256] == d[i], "R2", "write data",
                      log_data[(start + i) % 256], d[i]);
                p = next_ptr(p, inc);
            end
        end
        check(wr_ptr == p, extra_bits > 0 ? "R7" : (inc ? "R4" : "R6"),
              "pointer after frame", wr_ptr, p);
        exp_ptr = p;
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check(wr_ptr == 13'h0, "R1", "reset pointer", wr_ptr, 0);
        check(ram_we == 1'b0, "R1", "reset write strobe", ram_we, 0);

        // Directed corners.
        run_frame(8'h7A, 4, 0, 1'b1);          // R2 R4 basic stream
        load_ptr(13'h1FFE);
        run_frame(8'h7A, 3, 0, 1'b1);          // R5 wrap through 1FFF
        run_frame(8'h7A, 3, 0, 1'b0);          // R6 fixed address
        run_frame(8'h7B, 3, 0, 1'b1);          // R3 argument mismatch
        run_frame(8'h5A, 2, 0, 1'b1);          // R3 opcode mismatch
        run_frame(8'h7A, 2, 5, 1'b1);          // R7 partial byte dropped
        run_frame(8'h7A, 1, 0, 1'b1);          // R7 next frame fresh
        run_frame(8'h7A, 0, 3, 1'b1);          // R7 partial first data byte

        // Constrained random frames.
        for (int f = 0; f < 30; f++) begin
            logic [7:0] cmd;
            if (($urandom % 4) == 0) load_ptr((($urandom % 2) == 0)
                ? 13'h1FFF - 13'($urandom % 4) : 13'($urandom));
            cmd = (($urandom % 5) == 0) ? 8'($urandom) : 8'h7A;
            run_frame(cmd, int'($urandom % 7), (($urandom % 4) == 0) ? int'(1 + $urandom % 7) : 0,
                      1'($urandom % 4 != 0));
        end

        check(so_bad == 0, "R9", "serial output enable samples", so_bad, 0);
        check(we_bad == 0, "R10", "back-to-back write strobes", we_bad, 0);
        report();
        $finish;
    end
endmodule